// File: doc/BRIEF.md
# Bus Master Error Interrupt Capture

This block sits beside the initiator side of a bus host bridge. It collects the error events that the initiator sees and turns them into interrupt requests. There are six sources: a parity error on read data, a parity error reported by the target (during a write, or during the address phase of a read), expiry of the retry time-out, a master abort, a target abort, and a system-error signal raised by another device on the bus. Each event arrives as a one-cycle pulse on its own bit of `err_evt`. The address and command of the bus cycle in progress arrive alongside the events.

Each source has two control bits: an enable, and a routing bit that chooses between the maskable line and the non-maskable line. A raw status bit records every detection, whether the source is enabled or not. An enabled detection also sets a pending bit, which drives one of the two level outputs. The address and command of the cycle that produced the first enabled error are frozen in capture registers. They stay frozen until software has cleared every enabled pending bit.

Software uses a small register port. Writes take effect on the clock edge, and read data is combinational. The bus protocol, the retry counter and the interrupt controller itself are outside the block.

Top module: `mst_err_irq`

## Requirements
- R1: Source bit order in `err_evt` and in every per-source register is: 0 read-data parity, 1 parity reported by target, 2 retry time-out, 3 master abort, 4 target abort, 5 system error. An event sets its raw status bit at the next edge, whether or not the source is enabled.
- R2: An event sets its pending bit only when the enable bit of that source is 1.
- R3: Writing 1 to a bit of the pending register or the raw status register clears that bit, and writing 0 leaves it unchanged. An event arriving in the same cycle as a clear of its own bit wins, so the bit stays set.
- R4: `irq_mask` is high exactly while some source is pending, enabled, and has its routing bit at 0.
- R5: `irq_nmi` is high exactly while some source is pending, enabled, and has its routing bit at 1.
- R6: When no enabled pending bit is set at the start of a cycle and an enabled event occurs, the capture registers take that cycle's address and command. Bit 8 of the command register then reads 1 while any enabled pending bit remains set.
- R7: While any enabled pending bit is set, the capture registers do not change, even if further enabled events occur.
- R8: Once every enabled pending bit has been cleared, the next enabled event overwrites the capture registers.
- R9: When several sources fire in the same cycle, all of their pending bits are set, and the capture takes that cycle's address and command.
- R10: Synchronous active-low reset clears the enables, the routing bits, the pending bits, the raw status bits and both capture registers, and drives both outputs low.
- R11: An event from a disabled source neither raises an output nor changes the capture registers.
- R12: Register map on `reg_addr`: 0 enable, 1 routing (1 = NMI), 2 pending, 3 raw status, 4 captured address (read only), 5 captured command in the low bits with the held flag in bit 8 (read only). Unused read bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| err_evt | input | 6 | One-cycle error event pulses, one bit per source |
| cyc_addr | input | ADDR_W | Address of the current bus cycle |
| cyc_cmd | input | CMD_W | Command of the current bus cycle |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 6 | Register write data |
| reg_rdata | output | DATA_W | Register read data (combinational) |
| irq_mask | output | 1 | Maskable interrupt request, level |
| irq_nmi | output | 1 | Non-maskable interrupt request, level |

## Verification
The bench builds the block with a 24-bit address and a 4-bit command. Test addresses that set the top bit therefore show whether the capture path carries the full width into the read mux, with zero fill above it. A vector walk takes the block through a first capture, a frozen capture under a second source, write-zero and write-one clears, a two-source event, and a disabled source. Directed steps then cover an event that arrives together with its own clear, re-arming, NMI routing, and a reset in the middle of the run.

// File: rtl/mst_err_pkg.sv
// Package: shared constants for the bus master error interrupt block.
// Assumes: exactly six error sources, in the fixed bit order of the brief.
package mst_err_pkg;
    localparam int NSRC     = 6;
    localparam int HELD_BIT = 8;

    typedef enum logic [2:0] {
        REG_EN    = 3'd0,
        REG_ROUTE = 3'd1,
        REG_PEND  = 3'd2,
        REG_RAW   = 3'd3,
        REG_CADDR = 3'd4,
        REG_CCMD  = 3'd5
    } reg_sel_e;
endpackage

// File: rtl/err_flag_bank.sv
// Module: a bank of sticky flags with write-one-to-clear.
// Assumes: set_i pulses are sampled every clock; a set beats a clear on the same bit.
module err_flag_bank #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic         clr_we,
    input  logic [N-1:0] clr_mask,
    output logic [N-1:0] flags_o
);
    logic [N-1:0] clr_eff;

    // Purpose: gate the clear mask with the write strobe.
    always_comb clr_eff = clr_we ? clr_mask : '0;

    // Purpose: update the sticky flags; set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_o <= '0;
        else        flags_o <= (flags_o & ~clr_eff) | set_i;
    end

    for (genvar i = 0; i < N; i++) begin : g_chk
        assert_set_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> flags_o[i]);
    end

    assert_zero_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && clr_mask == '0 && set_i == '0) |=> $stable(flags_o));
endmodule

// File: rtl/err_capture.sv
// Module: holds the address and command of the cycle that raised an interrupt.
// Assumes: take_i is already qualified by the caller (enabled event while re-armed).
module err_capture #(
    parameter int ADDR_W = 32,
    parameter int CMD_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_i,
    input  logic [ADDR_W-1:0] cyc_addr,
    input  logic [CMD_W-1:0]  cyc_cmd,
    output logic [ADDR_W-1:0] cap_addr,
    output logic [CMD_W-1:0]  cap_cmd
);
    // Purpose: load both capture fields when a take is requested.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_addr <= '0;
            cap_cmd  <= '0;
        end else if (take_i) begin
            cap_addr <= cyc_addr;
            cap_cmd  <= cyc_cmd;
        end
    end

    assert_take_loads_R6: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |=> (cap_addr == $past(cyc_addr) && cap_cmd == $past(cyc_cmd)));
    assert_idle_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !take_i |=> ($stable(cap_addr) && $stable(cap_cmd)));
endmodule

// File: rtl/irq_route.sv
// Module: merges enabled pending flags onto the maskable and non-maskable lines.
// Assumes: route bit 1 selects the non-maskable line; outputs are combinational levels.
module irq_route #(
    parameter int N = 6
) (
    input  logic [N-1:0] pend_i,
    input  logic [N-1:0] en_i,
    input  logic [N-1:0] route_i,
    output logic         irq_mask,
    output logic         irq_nmi
);
    logic [N-1:0] live;

    // Purpose: form the live set and OR it onto each line by its route.
    always_comb begin
        live     = pend_i & en_i;
        irq_mask = |(live & ~route_i);
        irq_nmi  = |(live & route_i);
    end
endmodule

// File: rtl/mst_err_irq.sv
// Module: top of the bus master error interrupt block: control registers,
//         raw and pending status, first-error capture and interrupt routing.
// Assumes: ADDR_W <= DATA_W, CMD_W <= HELD_BIT, DATA_W > HELD_BIT.
module mst_err_irq
    import mst_err_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CMD_W  = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   err_evt,
    input  logic [ADDR_W-1:0] cyc_addr,
    input  logic [CMD_W-1:0]  cyc_cmd,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [NSRC-1:0]   reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_mask,
    output logic              irq_nmi
);
    logic [NSRC-1:0]   en_q, route_q, pend_q, raw_q;
    logic [NSRC-1:0]   pend_set;
    logic [ADDR_W-1:0] cap_addr;
    logic [CMD_W-1:0]  cap_cmd;
    logic              held, hit, take;
    logic              wr_pend, wr_raw;

    // Purpose: decode write strobes and the capture qualification.
    always_comb begin
        wr_pend  = reg_we && (reg_addr == REG_PEND);
        wr_raw   = reg_we && (reg_addr == REG_RAW);
        pend_set = err_evt & en_q;
        hit      = |pend_set;
        held     = |(pend_q & en_q);
        take     = hit && !held;
    end

    // Purpose: hold the enable and routing control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= '0;
            route_q <= '0;
        end else if (reg_we) begin
            if (reg_addr == REG_EN)    en_q    <= reg_wdata;
            if (reg_addr == REG_ROUTE) route_q <= reg_wdata;
        end
    end

    err_flag_bank #(.N(NSRC)) u_raw (
        .clk(clk), .rst_n(rst_n), .set_i(err_evt),
        .clr_we(wr_raw), .clr_mask(reg_wdata), .flags_o(raw_q)
    );

    err_flag_bank #(.N(NSRC)) u_pend (
        .clk(clk), .rst_n(rst_n), .set_i(pend_set),
        .clr_we(wr_pend), .clr_mask(reg_wdata), .flags_o(pend_q)
    );

    err_capture #(.ADDR_W(ADDR_W), .CMD_W(CMD_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .take_i(take),
        .cyc_addr(cyc_addr), .cyc_cmd(cyc_cmd),
        .cap_addr(cap_addr), .cap_cmd(cap_cmd)
    );

    irq_route #(.N(NSRC)) u_route (
        .pend_i(pend_q), .en_i(en_q), .route_i(route_q),
        .irq_mask(irq_mask), .irq_nmi(irq_nmi)
    );

    // Purpose: combinational read mux over the register map.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            REG_EN:    reg_rdata[NSRC-1:0]  = en_q;
            REG_ROUTE: reg_rdata[NSRC-1:0]  = route_q;
            REG_PEND:  reg_rdata[NSRC-1:0]  = pend_q;
            REG_RAW:   reg_rdata[NSRC-1:0]  = raw_q;
            REG_CADDR: reg_rdata[ADDR_W-1:0] = cap_addr;
            REG_CCMD: begin
                reg_rdata[CMD_W-1:0] = cap_cmd;
                reg_rdata[HELD_BIT]  = held;
            end
            default:   reg_rdata = '0;
        endcase
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_chk
        assert_no_unenabled_pend_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (!pend_q[i] && !(err_evt[i] && en_q[i]) && !reg_we) |=> !pend_q[i]);
    end

    assert_frozen_while_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        held |=> $stable(cap_addr));
    assert_rearm_loads_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !held) |=> (cap_addr == $past(cyc_addr)));
    assert_lines_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q == '0 && !hit) |=> (!irq_mask && !irq_nmi));
endmodule

// File: tb/sim_mst_err_irq.sv
module sim_mst_err_irq;
    localparam int AW = 24;
    localparam int CW = 4;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [5:0]    err_evt;
    logic [AW-1:0] cyc_addr;
    logic [CW-1:0] cyc_cmd;
    logic          reg_we;
    logic [2:0]    reg_addr;
    logic [5:0]    reg_wdata;
    logic [DW-1:0] reg_rdata;
    logic          irq_mask, irq_nmi;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    mst_err_irq #(.ADDR_W(AW), .CMD_W(CW), .DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .err_evt(err_evt), .cyc_addr(cyc_addr),
        .cyc_cmd(cyc_cmd), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_mask(irq_mask), .irq_nmi(irq_nmi)
    );

    typedef struct packed {
        logic          we;
        logic [2:0]    addr;
        logic [5:0]    wdata;
        logic [5:0]    evt;
        logic [AW-1:0] caddr;
        logic [CW-1:0] ccmd;
        logic          exp_m;
        logic          exp_n;
        logic [5:0]    exp_pend;
        logic [AW-1:0] exp_cap;
        logic [CW-1:0] exp_cmd;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 3'd0, 6'h3F, 6'h00, 24'h000000, 4'h0, 1'b0, 1'b0, 6'h00, 24'h000000, 4'h0}, // R12 enable all
        '{1'b1, 3'd1, 6'h30, 6'h00, 24'h000000, 4'h0, 1'b0, 1'b0, 6'h00, 24'h000000, 4'h0}, // R12 route 4,5 to NMI
        '{1'b0, 3'd0, 6'h00, 6'h08, 24'h801000, 4'h6, 1'b1, 1'b0, 6'h08, 24'h801000, 4'h6}, // R6 R4 first capture
        '{1'b0, 3'd0, 6'h00, 6'h10, 24'h002000, 4'h7, 1'b1, 1'b1, 6'h18, 24'h801000, 4'h6}, // R7 R5 frozen
        '{1'b1, 3'd2, 6'h08, 6'h00, 24'h000000, 4'h0, 1'b0, 1'b1, 6'h10, 24'h801000, 4'h6}, // R3 clear one
        '{1'b1, 3'd2, 6'h00, 6'h00, 24'h000000, 4'h0, 1'b0, 1'b1, 6'h10, 24'h801000, 4'h6}, // R3 write zero
        '{1'b1, 3'd2, 6'h10, 6'h00, 24'h000000, 4'h0, 1'b0, 1'b0, 6'h00, 24'h801000, 4'h6}, // R3 clear last
        '{1'b0, 3'd0, 6'h00, 6'h21, 24'hC03000, 4'hA, 1'b1, 1'b1, 6'h21, 24'hC03000, 4'hA}, // R9 R8 two sources
        '{1'b1, 3'd2, 6'h21, 6'h00, 24'h000000, 4'h0, 1'b0, 1'b0, 6'h00, 24'hC03000, 4'hA}, // R3 clear both
        '{1'b1, 3'd0, 6'h3E, 6'h00, 24'h000000, 4'h0, 1'b0, 1'b0, 6'h00, 24'hC03000, 4'hA}, // R12 disable src 0
        '{1'b0, 3'd0, 6'h00, 6'h01, 24'h004000, 4'h9, 1'b0, 1'b0, 6'h00, 24'hC03000, 4'hA}, // R11 R2 disabled
        '{1'b0, 3'd0, 6'h00, 6'h02, 24'h005000, 4'h3, 1'b1, 1'b0, 6'h02, 24'h005000, 4'h3}  // R8 R4 rearm
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input logic we, input logic [2:0] a, input logic [5:0] wd,
                        input logic [5:0] ev, input logic [AW-1:0] ca, input logic [CW-1:0] cc);
        reg_we = we; reg_addr = a; reg_wdata = wd;
        err_evt = ev; cyc_addr = ca; cyc_cmd = cc;
        @(posedge clk);
        #2;
        reg_we = 1'b0; err_evt = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        err_evt = '0; cyc_addr = '0; cyc_cmd = '0;
        repeat (2) @(posedge clk);
        #2;
        rst_n = 1'b1;

        // R10 reset state
        check("R10 irq_mask", {31'd0, irq_mask}, 0);
        check("R10 irq_nmi", {31'd0, irq_nmi}, 0);
        for (int r = 0; r < 6; r++) begin
            rd(3'(r), v);
            check("R10 register", v, 0);
        end

        for (int k = 0; k < NV; k++) begin
            step(VEC[k].we, VEC[k].addr, VEC[k].wdata, VEC[k].evt, VEC[k].caddr, VEC[k].ccmd);
            check("R4 irq_mask", {31'd0, irq_mask}, {31'd0, VEC[k].exp_m});
            check("R5 irq_nmi", {31'd0, irq_nmi}, {31'd0, VEC[k].exp_n});
            rd(3'd2, v); check("R2 pending", v, {26'd0, VEC[k].exp_pend});
            rd(3'd4, v); check("R6 cap addr", v, {8'd0, VEC[k].exp_cap});
            rd(3'd5, v); check("R7 cap cmd", {28'd0, v[3:0]}, {28'd0, VEC[k].exp_cmd});
        end

        // R1 raw status records disabled source 0 too
        rd(3'd3, v); check("R1 raw", v, 32'h3B);
        // R6 held flag set while pending
        rd(3'd5, v); check("R6 held flag", v, 32'h103);
        // R3 write one clears raw bit 0
        step(1'b1, 3'd3, 6'h01, 6'h00, '0, '0);
        rd(3'd3, v); check("R3 raw clear", v, 32'h3A);
        // R3 event beats clear of the same bit; R7 capture unchanged
        step(1'b1, 3'd2, 6'h02, 6'h02, 24'h006000, 4'h5);
        rd(3'd2, v); check("R3 set wins", v, 32'h02);
        rd(3'd4, v); check("R7 cap held", v, 32'h005000);
        // R8 clear rearms, held flag drops
        step(1'b1, 3'd2, 6'h02, 6'h00, '0, '0);
        check("R4 mask low", {31'd0, irq_mask}, 0);
        rd(3'd5, v); check("R8 held flag clear", v, 32'h003);
        // R5 all routed to NMI, retry time-out
        step(1'b1, 3'd1, 6'h3F, 6'h00, '0, '0);
        step(1'b0, 3'd0, 6'h00, 6'h04, 24'h007000, 4'hB);
        check("R5 nmi high", {31'd0, irq_nmi}, 1);
        check("R5 mask low", {31'd0, irq_mask}, 0);
        rd(3'd4, v); check("R8 new capture", v, 32'h007000);
        // R10 reset mid-run
        rst_n = 1'b0;
        @(posedge clk);
        #2;
        rst_n = 1'b1;
        check("R10 nmi after reset", {31'd0, irq_nmi}, 0);
        rd(3'd0, v); check("R10 enable", v, 0);
        rd(3'd1, v); check("R10 route", v, 0);
        rd(3'd2, v); check("R10 pending", v, 0);
        rd(3'd3, v); check("R10 raw", v, 0);
        rd(3'd4, v); check("R10 cap addr", v, 0);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule